// File: doc/BRIEF.md
# Low-Power State Sequencer for a Motor Controller

This block decides when a motor controller leaves normal operation for a low-power state, and how it comes back. A single target-select input chooses the low-power state. When it is 1 the target is sleep, where everything is switched off. When it is 0 the target is standby, where only the gate drivers are switched off. The conditions that send the block down, and those that bring it back, depend on where the speed command comes from: an analog level, a PWM duty cycle, a frequency, or a value written to a register. Each source has its own qualification time.

All analog and timing measurements happen outside the block and arrive as flags. Those flags are: the combined speed/wake pin is logic-low or logic-high, an analog level is under its entry level or over its exit level, and the measured duty or frequency is under its entry limit or over its exit limit. The register-written speed value arrives as a number together with its two thresholds. Detection times are counts of an internal tick that is derived from the clock. A condition has to hold without a break for the whole count. If it drops early, its timer starts again from zero.

On the way back up, outputs are switched on in a fixed order, one tick per step. First come the regulators, then the sense amplifier and the serial bus, and last the gate drivers. The active-low fault output stays low whenever the regulators are off. That covers power-up and the sleep state.

Top module: `lpm_ctrl`

## Requirements
- R1: After synchronous reset, every enable output and `fault_n` are 0.
- R2: Power-up and wake from sleep switch outputs on in this order, one tick apart: `reg_en` first, then `amp_en` and `bus_en` together, then `gate_en`. Leaving standby skips the first step, because the regulators are already on. `gate_en` is never 1 unless the other three enables are 1.
- R3: If `lp_sleep_sel` is 1, the low-power state is sleep: all four enables are 0 and `fault_n` is 0. If `lp_sleep_sel` is 0, it is standby: `gate_en` is 0 while `reg_en`, `amp_en`, `bus_en` and `fault_n` are 1.
- R4: With `spd_src`=00 (analog) and sleep as the target, sleep is entered once `ana_below_ent` has held for `t_ana_det` ticks when `ent_time_sel` is 00 or 01, or for `t_lp_det` ticks when it is 10 or 11. `ana_above_exit` causes an immediate exit.
- R5: With `spd_src`=01 (PWM) or 10 (frequency) and sleep as the target, sleep is entered after `wake_lo` has held for `t_lp_det` ticks. It is left after `wake_hi` has held for `t_wake_det` ticks.
- R6: With `spd_src`=01 and standby as the target, standby is entered after `duty_below_ent` has held for `t_lp_det` ticks. It is left after `duty_above_exit` has held for `t_wake_det` ticks.
- R7: With `spd_src`=10 and standby as the target, only `freq_below_ent` and `freq_above_exit` count, with the same times as R6. The duty flags are ignored.
- R8: With `spd_src`=11 (register) and standby as the target, standby is entered at once when `wake_lo` is 1 or `dig_speed` < `dig_ent_thr`. It is left only when `wake_hi` is 1 and `dig_speed` > `dig_exit_thr` at the same time. With sleep as the target, `wake_lo` enters and `wake_hi` exits, both immediately.
- R9: A qualification timer returns to zero on any clock cycle in which its condition is false. A broken condition therefore has to build up its full count again.
- R10: `fault_n` is 0 exactly while the regulators are off, and it is 1 once they are on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_sleep_sel | input | 1 | Low-power target: 1 sleep, 0 standby |
| spd_src | input | 2 | Speed source: 00 analog, 01 PWM, 10 frequency, 11 register |
| ent_time_sel | input | 2 | Analog sleep-entry time select |
| wake_lo | input | 1 | Speed/wake pin is logic-low |
| wake_hi | input | 1 | Speed/wake pin is logic-high |
| ana_below_ent | input | 1 | Analog level under entry level |
| ana_above_exit | input | 1 | Analog level over exit level |
| duty_below_ent | input | 1 | Measured duty under entry limit |
| duty_above_exit | input | 1 | Measured duty over exit limit |
| freq_below_ent | input | 1 | Measured frequency under entry limit |
| freq_above_exit | input | 1 | Measured frequency over exit limit |
| dig_speed | input | SPD_W | Register-written speed value |
| dig_ent_thr | input | SPD_W | Register-source entry threshold |
| dig_exit_thr | input | SPD_W | Register-source exit threshold |
| t_ana_det | input | CNT_W | Analog entry detect time, in ticks |
| t_lp_det | input | CNT_W | Low-power entry detect time, in ticks |
| t_wake_det | input | CNT_W | Wake detect time, in ticks |
| gate_en | output | 1 | Gate driver enable |
| reg_en | output | 1 | Internal regulator enable |
| amp_en | output | 1 | Sense amplifier enable |
| bus_en | output | 1 | Serial bus enable |
| fault_n | output | 1 | Active-low fault pin |

## Verification
The main function is exercised with each speed source in turn. Each test holds a condition for a time a little under its detect count and then a little over it. This shows whether the right timer and the right count were selected: for example, the analog entry-time field gives different results at 00 and at 10. A broken-then-resumed hold shows whether the timer restarts. PWM standby entry is also driven with random hold lengths, and these are kept clear of the one-tick uncertainty. The frequency source is given a duty-only pattern, to show that it ignores the duty flags. The register source is given its speed value between the two thresholds and a pin-low event on its own, which separates the OR rule for entry from the AND rule for exit.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_UP_REG = 3'd1,
    ST_UP_AUX = 3'd2,
    ST_ACTIVE = 3'd3,
    ST_SLEEP  = 3'd4,
    ST_STBY   = 3'd5
  } lp_state_e;

  typedef enum logic [1:0] {
    SRC_ANALOG = 2'b00,
    SRC_PWM    = 2'b01,
    SRC_FREQ   = 2'b10,
    SRC_REG    = 2'b11
  } spd_src_e;

endpackage

// File: rtl/lpm_tick.sv
module lpm_tick #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/lpm_qual.sv
module lpm_qual #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          cond,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt;
  logic          hold;

  assign hold = en && cond;

  always_ff @(posedge clk) begin
    if (rst || !hold) begin
      cnt <= '0;
    end else if (tick && (cnt != '1)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = hold && (cnt >= limit);

  // R9: a broken condition discards accumulated time
  a_r9_restart_on_drop: assert property (@(posedge clk) disable iff (rst)
    !(en && cond) |=> (cnt == '0));
endmodule

// File: rtl/lpm_cond.sv
module lpm_cond
  import lpm_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int SPD_W = 8
) (
  input  logic             to_sleep,
  input  logic             in_sleep,
  input  logic [1:0]       src,
  input  logic [1:0]       ent_sel,
  input  logic             wake_lo,
  input  logic             wake_hi,
  input  logic             ana_below,
  input  logic             ana_above,
  input  logic             duty_below,
  input  logic             duty_above,
  input  logic             freq_below,
  input  logic             freq_above,
  input  logic [SPD_W-1:0] dig,
  input  logic [SPD_W-1:0] dig_ent,
  input  logic [SPD_W-1:0] dig_ex,
  input  logic [CNT_W-1:0] t_ana,
  input  logic [CNT_W-1:0] t_lp,
  input  logic [CNT_W-1:0] t_wake,
  output logic             ent_c,
  output logic [CNT_W-1:0] ent_t,
  output logic             ex_c,
  output logic [CNT_W-1:0] ex_t
);
  logic       dig_lo, dig_hi, long_ana;
  spd_src_e   s;

  assign s        = spd_src_e'(src);
  assign dig_lo   = dig < dig_ent;
  assign dig_hi   = dig > dig_ex;
  assign long_ana = (ent_sel == 2'b10) || (ent_sel == 2'b11);

  always_comb begin
    ent_c = 1'b0;
    ent_t = '0;
    if (to_sleep) begin
      unique case (s)
        SRC_ANALOG: begin ent_c = ana_below; ent_t = long_ana ? t_lp : t_ana; end
        SRC_PWM,
        SRC_FREQ:   begin ent_c = wake_lo; ent_t = t_lp; end
        default:    ent_c = wake_lo;
      endcase
    end else begin
      unique case (s)
        SRC_ANALOG: ent_c = ana_below;
        SRC_PWM:    begin ent_c = duty_below; ent_t = t_lp; end
        SRC_FREQ:   begin ent_c = freq_below; ent_t = t_lp; end
        default:    ent_c = wake_lo || dig_lo;
      endcase
    end
  end

  always_comb begin
    ex_c = 1'b0;
    ex_t = '0;
    if (in_sleep) begin
      unique case (s)
        SRC_ANALOG: ex_c = ana_above;
        SRC_PWM,
        SRC_FREQ:   begin ex_c = wake_hi; ex_t = t_wake; end
        default:    ex_c = wake_hi;
      endcase
    end else begin
      unique case (s)
        SRC_ANALOG: ex_c = ana_above;
        SRC_PWM:    begin ex_c = duty_above; ex_t = t_wake; end
        SRC_FREQ:   begin ex_c = freq_above; ex_t = t_wake; end
        default:    ex_c = wake_hi && dig_hi;
      endcase
    end
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int TICK_DIV = 50,
  parameter int CNT_W    = 12,
  parameter int SPD_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lp_sleep_sel,
  input  logic [1:0]       spd_src,
  input  logic [1:0]       ent_time_sel,
  input  logic             wake_lo,
  input  logic             wake_hi,
  input  logic             ana_below_ent,
  input  logic             ana_above_exit,
  input  logic             duty_below_ent,
  input  logic             duty_above_exit,
  input  logic             freq_below_ent,
  input  logic             freq_above_exit,
  input  logic [SPD_W-1:0] dig_speed,
  input  logic [SPD_W-1:0] dig_ent_thr,
  input  logic [SPD_W-1:0] dig_exit_thr,
  input  logic [CNT_W-1:0] t_ana_det,
  input  logic [CNT_W-1:0] t_lp_det,
  input  logic [CNT_W-1:0] t_wake_det,
  output logic             gate_en,
  output logic             reg_en,
  output logic             amp_en,
  output logic             bus_en,
  output logic             fault_n
);
  lp_state_e        state;
  logic             tick;
  logic             in_active, in_low, in_sleep;
  logic             ent_c, ex_c, ent_done, ex_done;
  logic [CNT_W-1:0] ent_t, ex_t;

  assign in_active = (state == ST_ACTIVE);
  assign in_sleep  = (state == ST_SLEEP);
  assign in_low    = in_sleep || (state == ST_STBY);

  lpm_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  lpm_cond #(.CNT_W(CNT_W), .SPD_W(SPD_W)) u_cond (
    .to_sleep(lp_sleep_sel), .in_sleep(in_sleep), .src(spd_src),
    .ent_sel(ent_time_sel), .wake_lo(wake_lo), .wake_hi(wake_hi),
    .ana_below(ana_below_ent), .ana_above(ana_above_exit),
    .duty_below(duty_below_ent), .duty_above(duty_above_exit),
    .freq_below(freq_below_ent), .freq_above(freq_above_exit),
    .dig(dig_speed), .dig_ent(dig_ent_thr), .dig_ex(dig_exit_thr),
    .t_ana(t_ana_det), .t_lp(t_lp_det), .t_wake(t_wake_det),
    .ent_c(ent_c), .ent_t(ent_t), .ex_c(ex_c), .ex_t(ex_t)
  );

  lpm_qual #(.CW(CNT_W)) u_ent_q (
    .clk(clk), .rst(rst), .en(in_active), .cond(ent_c), .tick(tick),
    .limit(ent_t), .done(ent_done)
  );

  lpm_qual #(.CW(CNT_W)) u_ex_q (
    .clk(clk), .rst(rst), .en(in_low), .cond(ex_c), .tick(tick),
    .limit(ex_t), .done(ex_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_OFF;
    end else begin
      unique case (state)
        ST_OFF:    if (tick) state <= ST_UP_REG;
        ST_UP_REG: if (tick) state <= ST_UP_AUX;
        ST_UP_AUX: if (tick) state <= ST_ACTIVE;
        ST_ACTIVE: if (ent_done) state <= lp_sleep_sel ? ST_SLEEP : ST_STBY;
        ST_SLEEP:  if (ex_done) state <= ST_UP_REG;
        ST_STBY:   if (ex_done) state <= ST_UP_AUX;
        default:   state <= ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_en  <= 1'b0;
      amp_en  <= 1'b0;
      bus_en  <= 1'b0;
      gate_en <= 1'b0;
      fault_n <= 1'b0;
    end else begin
      reg_en  <= state inside {ST_UP_REG, ST_UP_AUX, ST_ACTIVE, ST_STBY};
      amp_en  <= state inside {ST_UP_AUX, ST_ACTIVE, ST_STBY};
      bus_en  <= state inside {ST_UP_AUX, ST_ACTIVE, ST_STBY};
      gate_en <= in_active;
      fault_n <= state inside {ST_UP_REG, ST_UP_AUX, ST_ACTIVE, ST_STBY};
    end
  end

  // R2: gate drivers come up only after amplifier, bus and regulators
  a_r2_gate_last: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_en) |-> ($past(amp_en) && $past(bus_en) && $past(reg_en)));

  // R2: amplifier comes up only after regulators
  a_r2_amp_after_reg: assert property (@(posedge clk) disable iff (rst)
    $rose(amp_en) |-> $past(reg_en));

  // R3: sleep switches every enable off
  a_r3_sleep_all_off: assert property (@(posedge clk) disable iff (rst)
    in_sleep |=> (!reg_en && !amp_en && !bus_en && !gate_en));

  // R10: fault pin released while running
  a_r10_fault_released: assert property (@(posedge clk) disable iff (rst)
    in_active |=> fault_n);

  // R10: fault pin low in sleep
  a_r10_fault_low_sleep: assert property (@(posedge clk) disable iff (rst)
    in_sleep |=> !fault_n);
endmodule

// File: tb/lpm_ctrl_test.sv
module lpm_ctrl_test;
  localparam int DIV = 4;
  localparam int CW  = 8;
  localparam int SW  = 8;
  localparam int TA  = 2;
  localparam int TL  = 5;
  localparam int TW  = 3;
  localparam logic [4:0] P_ACT = 5'b11111;
  localparam logic [4:0] P_SLP = 5'b00000;
  localparam logic [4:0] P_SBY = 5'b11101;
  localparam logic [4:0] P_UPR = 5'b10001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lp_sleep_sel;
  logic [1:0] spd_src, ent_time_sel;
  logic wake_lo, wake_hi, ana_below_ent, ana_above_exit;
  logic duty_below_ent, duty_above_exit, freq_below_ent, freq_above_exit;
  logic [SW-1:0] dig_speed, dig_ent_thr, dig_exit_thr;
  logic [CW-1:0] t_ana_det, t_lp_det, t_wake_det;
  logic gate_en, reg_en, amp_en, bus_en, fault_n;
  logic [4:0] outs;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  assign outs = {reg_en, amp_en, bus_en, gate_en, fault_n};

  lpm_ctrl #(.TICK_DIV(DIV), .CNT_W(CW), .SPD_W(SW)) uut (
    .clk(clk), .rst(rst), .lp_sleep_sel(lp_sleep_sel), .spd_src(spd_src),
    .ent_time_sel(ent_time_sel), .wake_lo(wake_lo), .wake_hi(wake_hi),
    .ana_below_ent(ana_below_ent), .ana_above_exit(ana_above_exit),
    .duty_below_ent(duty_below_ent), .duty_above_exit(duty_above_exit),
    .freq_below_ent(freq_below_ent), .freq_above_exit(freq_above_exit),
    .dig_speed(dig_speed), .dig_ent_thr(dig_ent_thr), .dig_exit_thr(dig_exit_thr),
    .t_ana_det(t_ana_det), .t_lp_det(t_lp_det), .t_wake_det(t_wake_det),
    .gate_en(gate_en), .reg_en(reg_en), .amp_en(amp_en), .bus_en(bus_en),
    .fault_n(fault_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] act,
                     input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input logic [4:0] exp);
    chk(outs == exp, tag, {3'b0, outs}, {3'b0, exp});
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // A hold longer than this many cycles always spans enough ticks
  function automatic bit exp_enter(input int hold, input int lim);
    return hold >= (lim + 1) * DIV + 4;
  endfunction

  task automatic idle();
    wake_lo = 1'b0; wake_hi = 1'b1;
    ana_below_ent = 1'b0; ana_above_exit = 1'b1;
    duty_below_ent = 1'b0; duty_above_exit = 1'b1;
    freq_below_ent = 1'b0; freq_above_exit = 1'b1;
    dig_speed = 8'd100;
  endtask

  // R2 ordering monitor on every rising enable
  logic p_reg = 1'b0, p_amp = 1'b0, p_bus = 1'b0, p_gate = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (amp_en && !p_amp)
        chk(p_reg, "R2 amp rose without reg", {7'b0, p_reg}, 8'd1);
      if (gate_en && !p_gate)
        chk(p_amp && p_bus, "R2 gate rose before amp/bus",
            {6'b0, p_amp, p_bus}, 8'd3);
    end
    p_reg = reg_en; p_amp = amp_en; p_bus = bus_en; p_gate = gate_en;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    idle();
    lp_sleep_sel = 1'b1; spd_src = 2'b00; ent_time_sel = 2'b00;
    dig_ent_thr = 8'd20; dig_exit_thr = 8'd40;
    t_ana_det = CW'(TA); t_lp_det = CW'(TL); t_wake_det = CW'(TW);
    cyc(5);
    rst = 1'b0;
    cyc(1);
    chk_out("R1 reset outputs", P_SLP);
    chk(fault_n == 1'b0, "R10 fault low at power-up", {7'b0, fault_n}, 8'd0);
    cyc(20);
    chk_out("R2 power-up complete", P_ACT);

    // R4 analog sleep, short entry time
    ana_below_ent = 1'b1; ana_above_exit = 1'b0;
    cyc((TA - 1) * DIV - 1);
    chk_out("R4 analog sel00 early", P_ACT);
    cyc(16);
    chk_out("R4 analog sel00 sleep", P_SLP);
    ana_below_ent = 1'b0; ana_above_exit = 1'b1;
    cyc(2);
    chk_out("R2 wake step regulators", P_UPR);
    cyc(16);
    chk_out("R4 analog exit", P_ACT);

    // R4 analog sleep, long entry time
    ent_time_sel = 2'b10;
    ana_below_ent = 1'b1; ana_above_exit = 1'b0;
    cyc((TL - 1) * DIV - 1);
    chk_out("R4 analog sel10 early", P_ACT);
    cyc(16);
    chk_out("R4 analog sel10 sleep", P_SLP);
    idle();
    cyc(20);
    chk_out("R4 analog exit 2", P_ACT);

    // R9 restart, R5 PWM sleep
    spd_src = 2'b01;
    wake_lo = 1'b1; wake_hi = 1'b0;
    cyc((TL - 1) * DIV - 1);
    wake_lo = 1'b0; wake_hi = 1'b1;
    cyc(2);
    wake_lo = 1'b1; wake_hi = 1'b0;
    cyc((TL - 1) * DIV - 1);
    chk_out("R9 timer restart", P_ACT);
    cyc(16);
    chk_out("R5 pwm sleep entry", P_SLP);
    wake_lo = 1'b0; wake_hi = 1'b1;
    cyc((TW - 1) * DIV - 1);
    chk_out("R5 pwm wake early", P_SLP);
    cyc(33);
    chk_out("R5 pwm wake", P_ACT);

    // R6 PWM standby with random hold lengths
    lp_sleep_sel = 1'b0;
    for (int i = 0; i < 8; i++) begin
      int hold;
      bit enter;
      hold = ($urandom % 2 == 1) ? 28 + int'($urandom % 10) : 1 + int'($urandom % 15);
      enter = exp_enter(hold, TL);
      duty_below_ent = 1'b1; duty_above_exit = 1'b0;
      cyc(hold);
      duty_below_ent = 1'b0;
      cyc(3);
      chk_out("R6 pwm standby entry", enter ? P_SBY : P_ACT);
      duty_above_exit = 1'b1;
      cyc(40);
      chk_out("R6 pwm standby exit", P_ACT);
    end

    // R7 frequency source ignores duty
    spd_src = 2'b10;
    duty_below_ent = 1'b1; duty_above_exit = 1'b0;
    cyc(40);
    chk_out("R7 duty ignored", P_ACT);
    idle();
    freq_below_ent = 1'b1; freq_above_exit = 1'b0;
    cyc(40);
    chk_out("R7 freq standby", P_SBY);
    freq_below_ent = 1'b0; freq_above_exit = 1'b1;
    cyc(40);
    chk_out("R7 freq exit", P_ACT);

    // R8 register source
    spd_src = 2'b11;
    dig_speed = 8'd10;
    cyc(4);
    chk_out("R8 speed below entry", P_SBY);
    dig_speed = 8'd30;
    cyc(20);
    chk_out("R8 between thresholds stays", P_SBY);
    dig_speed = 8'd50; wake_hi = 1'b0; wake_lo = 1'b1;
    cyc(20);
    chk_out("R8 pin low blocks exit", P_SBY);
    wake_lo = 1'b0; wake_hi = 1'b1;
    cyc(20);
    chk_out("R8 exit needs both", P_ACT);
    wake_lo = 1'b1; wake_hi = 1'b0;
    cyc(4);
    chk_out("R8 pin low enters", P_SBY);
    wake_lo = 1'b0; wake_hi = 1'b1;
    cyc(20);
    chk_out("R8 exit 2", P_ACT);

    // R3 sleep target with register source
    lp_sleep_sel = 1'b1;
    wake_lo = 1'b1; wake_hi = 1'b0;
    cyc(4);
    chk_out("R3 sleep pattern", P_SLP);
    chk(fault_n == 1'b0, "R10 fault low in sleep", {7'b0, fault_n}, 8'd0);
    wake_lo = 1'b0; wake_hi = 1'b1;
    cyc(20);
    chk_out("R3 sleep exit", P_ACT);
    chk(fault_n == 1'b1, "R10 fault released", {7'b0, fault_n}, 8'd1);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule